// File: doc/BRIEF.md
# Host Command Decoder with Start-up Enumeration

This block sits between a host byte link and the units that run a chain of pixel detectors. Bytes arrive from the host on a valid/ready byte interface. The block groups them into fixed-size commands: one opcode byte followed by a three-byte argument. Each command with a recognised opcode is handed to the downstream units as a single-cycle strobe, together with the opcode and the assembled argument. A command with an unrecognised opcode is dropped and raises a sticky error flag.

Commands are not accepted straight after reset. The block first asks the acquisition unit how many detectors are on the chain and waits for the answer. It then sends the host a fixed five-byte status report on a second valid/ready byte interface. Only after the last report byte has been taken does it open the command input. Until then the host is held off by keeping the receive-ready signal low.

Top module: `hcd_top`

## Requirements
- R1: While reset is held and in the first cycle after release, `enum_req` is 1 and `rx_ready`, `tx_valid`, `cmd_stb` and `cmd_err` are 0.
- R2: `enum_req` stays high until a cycle in which `enum_done` is 1. The chain count on `enum_count` is captured in that same cycle, and later changes of `enum_count` have no effect.
- R3: The report is five bytes in this order: 0xA5, the chain count, the system clock in MHz (50), the readout clock in MHz (100, twice the system clock), and the firmware version 0x13. A byte is consumed only in a cycle with `tx_valid` and `tx_ready` both high. While it waits, `tx_valid` and `tx_data` stay unchanged.
- R4: `rx_ready` is 0 until the cycle after the last report byte is consumed. From then until reset it is 1, and no host byte is consumed before that point.
- R5: A command is four consumed bytes: the opcode first, then the argument most significant byte first, so `cmd_arg` = {byte1, byte2, byte3}. Idle cycles between bytes do not break the grouping.
- R6: For an opcode below 16, `cmd_stb` is 1 for exactly one cycle. That cycle is the one after the fourth byte is consumed, and in it `cmd_op` and `cmd_arg` carry the command.
- R7: For an opcode of 16 or more, no strobe is raised. All four bytes are still consumed, `cmd_err` becomes 1 and stays 1 until reset, and the commands that follow are decoded normally.
- R8: A chain count above 12 is reported as 12. Counts from 0 to 12 are reported unchanged.
- R9: `tx_valid` is never 1 together with `rx_ready` or together with `enum_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enum_req | output | 1 | Asks the acquisition unit to count the chain |
| enum_done | input | 1 | Chain count is valid this cycle |
| enum_count | input | 8 | Number of detectors found |
| tx_data | output | 8 | Report byte to the host |
| tx_valid | output | 1 | Report byte is valid |
| tx_ready | input | 1 | Host link takes the report byte |
| rx_data | input | 8 | Command byte from the host |
| rx_valid | input | 1 | Command byte is valid |
| rx_ready | output | 1 | Block takes the command byte |
| cmd_stb | output | 1 | One-cycle strobe for a decoded command |
| cmd_op | output | 8 | Opcode of the strobed command |
| cmd_arg | output | 24 | Argument of the strobed command |
| cmd_err | output | 1 | Sticky flag for an unknown opcode |

## Verification
The bench builds the block with its default parameters: a chain limit of 12, an opcode range of 16 and a three-byte argument. Random opcodes are drawn from 0 to 31, so about half of the commands are unknown and the error path is exercised alongside normal decoding. Two reset runs report chain counts of 13 and 5, which covers the clamp and the pass-through case. Random stalls on the report link and random gaps between host bytes test the hold-off before the report ends and the byte grouping across idle cycles.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
   typedef enum logic [1:0] {
      PH_ENUM   = 2'd0,
      PH_REPORT = 2'd1,
      PH_RUN    = 2'd2
   } phase_t;

   localparam int REPORT_LEN = 5;
   localparam int BYTE_W     = 8;
endpackage

// File: rtl/hcd_startup.sv
module hcd_startup
   import hcd_pkg::*;
#(
   parameter int          MAX_CHAIN  = 12,
   parameter int          CHAIN_IN_W = 8,
   parameter int          SYS_MHZ    = 50,
   parameter int          RO_MULT    = 2,
   parameter logic [7:0]  FW_VERSION = 8'h13,
   parameter logic [7:0]  HDR_BYTE   = 8'hA5
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enum_done,
   input  logic [CHAIN_IN_W-1:0] enum_count,
   input  logic                  tx_ready,
   output logic                  enum_req,
   output logic                  tx_valid,
   output logic [BYTE_W-1:0]     tx_data,
   output logic                  run
);
   localparam int IDX_W = $clog2(REPORT_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REPORT_LEN - 1);
   localparam logic [BYTE_W-1:0] SYS_B  = BYTE_W'(SYS_MHZ);
   localparam logic [BYTE_W-1:0] RO_B   = BYTE_W'(SYS_MHZ * RO_MULT);
   localparam logic [BYTE_W-1:0] MAX_B  = BYTE_W'(MAX_CHAIN);

   phase_t             phase;
   logic [IDX_W-1:0]   idx;
   logic [BYTE_W-1:0]  count_q;

   function automatic logic [BYTE_W-1:0] clamp_count(input logic [CHAIN_IN_W-1:0] c);
      if (32'(c) > MAX_CHAIN) return MAX_B;
      return BYTE_W'(c);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_ENUM;
         idx     <= '0;
         count_q <= '0;
      end else begin
         case (phase)
            PH_ENUM: begin
               if (enum_done) begin
                  count_q <= clamp_count(enum_count);
                  idx     <= '0;
                  phase   <= PH_REPORT;
               end
            end
            PH_REPORT: begin
               if (tx_ready) begin
                  if (idx == LAST_IDX) phase <= PH_RUN;
                  else                 idx   <= idx + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IDX_W'(0): tx_data = HDR_BYTE;
         IDX_W'(1): tx_data = count_q;
         IDX_W'(2): tx_data = SYS_B;
         IDX_W'(3): tx_data = RO_B;
         default:   tx_data = FW_VERSION;
      endcase
   end

   assign enum_req = (phase == PH_ENUM);
   assign tx_valid = (phase == PH_REPORT);
   assign run      = (phase == PH_RUN);
endmodule

// File: rtl/hcd_assembler.sv
module hcd_assembler
   import hcd_pkg::*;
#(
   parameter int PARAM_BYTES = 3
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable,
   input  logic                        rx_valid,
   input  logic [BYTE_W-1:0]           rx_data,
   output logic                        rx_ready,
   output logic                        frame_done,
   output logic [BYTE_W-1:0]           frame_op,
   output logic [BYTE_W*PARAM_BYTES-1:0] frame_arg
);
   localparam int ARG_W = BYTE_W * PARAM_BYTES;
   localparam int POS_W = $clog2(PARAM_BYTES + 1);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(PARAM_BYTES);

   logic [POS_W-1:0] pos;
   logic             take;

   assign rx_ready = enable;
   assign take     = rx_valid & enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos        <= '0;
         frame_done <= 1'b0;
         frame_op   <= '0;
         frame_arg  <= '0;
      end else begin
         frame_done <= 1'b0;
         if (take) begin
            if (pos == '0) begin
               frame_op <= rx_data;
               pos      <= pos + 1'b1;
            end else begin
               frame_arg <= (frame_arg << BYTE_W) | ARG_W'(rx_data);
               if (pos == LAST_POS) begin
                  pos        <= '0;
                  frame_done <= 1'b1;
               end else begin
                  pos <= pos + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/hcd_opfilter.sv
module hcd_opfilter
   import hcd_pkg::*;
#(
   parameter int NUM_OPCODES   = 16,
   parameter bit CHECK_OPCODES = 1'b1
)(
   input  logic [BYTE_W-1:0] op,
   output logic              known
);
   generate
      if (CHECK_OPCODES) begin : g_range
         assign known = (32'(op) < NUM_OPCODES);
      end else begin : g_open
         logic unused_op;
         assign unused_op = ^op;
         assign known     = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/hcd_top.sv
module hcd_top
   import hcd_pkg::*;
#(
   parameter int          MAX_CHAIN     = 12,
   parameter int          CHAIN_IN_W    = 8,
   parameter int          SYS_MHZ       = 50,
   parameter int          RO_MULT       = 2,
   parameter logic [7:0]  FW_VERSION    = 8'h13,
   parameter logic [7:0]  HDR_BYTE      = 8'hA5,
   parameter int          PARAM_BYTES   = 3,
   parameter int          NUM_OPCODES   = 16,
   parameter bit          CHECK_OPCODES = 1'b1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   output logic                          enum_req,
   input  logic                          enum_done,
   input  logic [CHAIN_IN_W-1:0]         enum_count,
   output logic [7:0]                    tx_data,
   output logic                          tx_valid,
   input  logic                          tx_ready,
   input  logic [7:0]                    rx_data,
   input  logic                          rx_valid,
   output logic                          rx_ready,
   output logic                          cmd_stb,
   output logic [7:0]                    cmd_op,
   output logic [8*PARAM_BYTES-1:0]      cmd_arg,
   output logic                          cmd_err
);
   generate
      if (MAX_CHAIN < 1 || MAX_CHAIN > 255)
         $error("hcd_top: MAX_CHAIN must lie in 1..255");
      if (CHAIN_IN_W < 1 || CHAIN_IN_W > 8)
         $error("hcd_top: CHAIN_IN_W must lie in 1..8");
      if (SYS_MHZ * RO_MULT > 255 || SYS_MHZ < 1 || RO_MULT < 1)
         $error("hcd_top: clock values must fit in one byte");
      if (PARAM_BYTES < 1 || PARAM_BYTES > 8)
         $error("hcd_top: PARAM_BYTES must lie in 1..8");
      if (NUM_OPCODES < 1 || NUM_OPCODES > 256)
         $error("hcd_top: NUM_OPCODES must lie in 1..256");
   endgenerate

   logic run;
   logic frame_done;
   logic known;

   hcd_startup #(
      .MAX_CHAIN  (MAX_CHAIN),
      .CHAIN_IN_W (CHAIN_IN_W),
      .SYS_MHZ    (SYS_MHZ),
      .RO_MULT    (RO_MULT),
      .FW_VERSION (FW_VERSION),
      .HDR_BYTE   (HDR_BYTE)
   ) u_startup (
      .clk        (clk),
      .rst_n      (rst_n),
      .enum_done  (enum_done),
      .enum_count (enum_count),
      .tx_ready   (tx_ready),
      .enum_req   (enum_req),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .run        (run)
   );

   hcd_assembler #(
      .PARAM_BYTES (PARAM_BYTES)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (run),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_ready   (rx_ready),
      .frame_done (frame_done),
      .frame_op   (cmd_op),
      .frame_arg  (cmd_arg)
   );

   hcd_opfilter #(
      .NUM_OPCODES   (NUM_OPCODES),
      .CHECK_OPCODES (CHECK_OPCODES)
   ) u_filter (
      .op    (cmd_op),
      .known (known)
   );

   assign cmd_stb = frame_done & known;

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_err <= 1'b0;
      else        cmd_err <= cmd_err | (frame_done & ~known);
   end
endmodule

// File: rtl/hcd_checker.sv
module hcd_checker #(
   parameter int NUM_OPCODES   = 16,
   parameter bit CHECK_OPCODES = 1'b1
)(
   input logic       clk,
   input logic       rst_n,
   input logic       enum_req,
   input logic       enum_done,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       rx_ready,
   input logic       cmd_stb,
   input logic [7:0] cmd_op,
   input logic       cmd_err
);
   assert_enum_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enum_req && !enum_done) |=> enum_req);

   assert_tx_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   assert_ready_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |=> rx_ready);

   assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> !cmd_stb);

   assert_stb_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> (!CHECK_OPCODES || (32'(cmd_op) < NUM_OPCODES)));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   assert_phase_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && rx_ready) && !(tx_valid && enum_req));
endmodule

bind hcd_top hcd_checker #(
   .NUM_OPCODES   (NUM_OPCODES),
   .CHECK_OPCODES (CHECK_OPCODES)
) u_hcd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .enum_req  (enum_req),
   .enum_done (enum_done),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .rx_ready  (rx_ready),
   .cmd_stb   (cmd_stb),
   .cmd_op    (cmd_op),
   .cmd_err   (cmd_err)
);

// File: tb/test_hcd_top.sv
module test_hcd_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enum_req, enum_done = 1'b0;
   logic [7:0]  enum_count = '0;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_ready = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic        cmd_stb;
   logic [7:0]  cmd_op;
   logic [23:0] cmd_arg;
   logic        cmd_err;

   int checks = 0;
   int errors = 0;
   logic [31:0] expq[$];
   logic [7:0]  rep[$];
   bit rx_fire;
   bit rnd_ready = 1'b0;
   bit any_unknown;

   always #4 clk = ~clk;

   hcd_top i_hcd_top (
      .clk(clk), .rst_n(rst_n), .enum_req(enum_req), .enum_done(enum_done),
      .enum_count(enum_count), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .cmd_err(cmd_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_count(input logic [7:0] c);
      return (c > 8'd12) ? 8'd12 : c;
   endfunction

   task automatic tick();
      logic [31:0] e;
      if (rnd_ready) tx_ready = 1'($urandom % 2);
      #1;
      rx_fire = rx_valid && rx_ready;
      if (tx_valid && tx_ready) rep.push_back(tx_data);
      if (cmd_stb) begin
         if (expq.size() == 0) chk(1'b0, "R7", "strobe with no pending command", {cmd_op, cmd_arg}, 32'h0);
         else begin
            e = expq.pop_front();
            chk({cmd_op, cmd_arg} == e, "R6", "strobed opcode and argument", {cmd_op, cmd_arg}, e);
         end
      end
      @(negedge clk);
   endtask

   task automatic start_up(input logic [7:0] cnt);
      bit early;
      int n;
      logic [7:0] exp_rep[5];
      rst_n = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0; enum_done = 1'b0;
      rnd_ready = 1'b0; rep.delete(); expq.delete(); any_unknown = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(enum_req && !rx_ready && !tx_valid && !cmd_stb && !cmd_err, "R1", "outputs during reset",
          {enum_req, rx_ready, tx_valid, cmd_stb, cmd_err}, 32'h10);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(enum_req && !rx_ready && !tx_valid && !cmd_stb && !cmd_err, "R1", "outputs after release",
          {enum_req, rx_ready, tx_valid, cmd_stb, cmd_err}, 32'h10);
      // host byte offered early must wait (R4); request held (R2)
      rx_valid = 1'b1; rx_data = 8'h01; early = 1'b0;
      repeat (6) begin tick(); if (rx_fire || !enum_req || tx_valid) early = 1'b1; end
      chk(!early, "R2", "request held and input closed before count", early, 0);
      enum_count = cnt; enum_done = 1'b1;
      tick();
      enum_done = 1'b0; enum_count = 8'd7;   // later value must be ignored (R2)
      rnd_ready = 1'b1; n = 0; early = 1'b0;
      while (rep.size() < 5 && n < 300) begin
         tick(); n++;
         if (rx_fire) early = 1'b1;
      end
      rx_valid = 1'b0; rnd_ready = 1'b0; tx_ready = 1'b0;
      chk(!early, "R4", "no host byte consumed during report", early, 0);
      chk(rep.size() == 5, "R3", "report length", rep.size(), 5);
      exp_rep = '{8'hA5, exp_count(cnt), 8'd50, 8'd100, 8'h13};
      for (int i = 0; i < 5; i++)
         if (i < rep.size())
            chk(rep[i] == exp_rep[i], (i == 1) ? "R8" : "R3", $sformatf("report byte %0d", i), rep[i], exp_rep[i]);
      tick();
      chk(rx_ready && !tx_valid && !enum_req, "R4", "input open after report",
          {rx_ready, tx_valid, enum_req}, 32'h4);
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_valid = 1'b1; rx_data = b;
      forever begin tick(); if (rx_fire) break; end
      rx_valid = 1'b0;
      repeat ($urandom % 3) tick();
   endtask

   task automatic send_cmd(input logic [7:0] op, input logic [23:0] arg);
      if (op < 8'd16) expq.push_back({op, arg});
      else any_unknown = 1'b1;
      send_byte(op);
      send_byte(arg[23:16]);
      send_byte(arg[15:8]);
      send_byte(arg[7:0]);
   endtask

   task automatic drain(input string req);
      repeat (4) tick();
      chk(expq.size() == 0, req, "pending commands after drain", expq.size(), 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      // first run: count above limit (R8)
      start_up(8'd13);
      send_cmd(8'h03, 24'hFFFFFF);          // R5 all-ones argument
      send_cmd(8'h0F, 24'h000000);          // R6 highest known opcode
      drain("R6");
      chk(cmd_err == 1'b0, "R7", "no error after known commands", cmd_err, 0);
      send_cmd(8'h10, 24'h123456);          // R7 lowest unknown opcode
      drain("R7");
      chk(cmd_err == 1'b1, "R7", "error after unknown opcode", cmd_err, 1);
      send_cmd(8'h00, 24'hABCDEF);          // R7 alignment kept after drop
      drain("R5");
      chk(cmd_err == 1'b1, "R7", "error stays set", cmd_err, 1);
      for (int i = 0; i < 30; i++) send_cmd(8'($urandom % 32), 24'($urandom));
      drain("R6");
      // second run: count inside the range, error cleared by reset
      start_up(8'd5);
      for (int i = 0; i < 25; i++) send_cmd(8'($urandom % 32), 24'($urandom));
      drain("R5");
      chk(cmd_err == any_unknown, "R7", "error matches unknown opcodes seen", cmd_err, any_unknown);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule